// File: doc/BRIEF.md
# Sequential/Nonsequential Memory Bus Sequencer

This block sits between a processor core and a 32-bit memory bus and turns each core access request (address, direction, size, write data) into bus cycles. When a request extends the burst already running on the bus, it costs a single sequential memory cycle. Any other request costs two cycles: an idle cycle, then a memory cycle. The address is presented from the start of the idle cycle, which gives the memory extra decode time.

Address, direction, size, memory-request and sequence-type outputs are pipelined. Their values in one cycle describe the following cycle. Write data is driven on the bus during the memory cycle itself. Read data is sampled at the end of the memory cycle and handed back to the core with a one-cycle valid pulse.

On the core side there is a valid/ready handshake. Ready drops for one cycle whenever an idle cycle has to be inserted.

Top module: `mem_bus_sequencer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `req_ready` is 1 and `bus_mreq`, `bus_seq`, `bus_doe` and `rd_valid` are all 0.
- R2: A request accepted at a clock edge that does not extend the burst is issued as nonsequential. In the next cycle `bus_mreq`=0 and `req_ready`=0, and the request's address and controls are already on the bus. In the cycle after that, `bus_mreq`=1 and `bus_seq`=0.
- R3: A request is issued as sequential when four conditions hold at its accepting edge. The bus is announcing a memory cycle. `req_write` and `req_word` equal the values on the bus. `req_addr` equals `bus_addr`+4. `req_addr` bits [9:2] are not all zero. A sequential request shows `bus_mreq`=1 and `bus_seq`=1 in the next cycle.
- R4: A change of direction (`bus_write`: 1 = write, 0 = read) or of size (`bus_word`: 1 = word, 0 = byte) forces a nonsequential access, even when the address is the previous one plus 4.
- R5: A request whose address bits [9:2] are zero, which marks a 256-word boundary, is issued as nonsequential. Sequential issue resumes with the request after it.
- R6: A cycle with `req_ready`=1 and no request leads to `bus_mreq`=0 and `bus_seq`=0 in the next cycle. The first request after such a gap is nonsequential.
- R7: Through the inserted idle cycle, `bus_addr`, `bus_write` and `bus_word` hold the values of the pending request.
- R8: `bus_doe` is 1 exactly in the cycle after a cycle with `bus_mreq`=1 and `bus_write`=1. In that cycle `bus_dout` carries the write data of that request.
- R9: A read memory cycle samples `bus_rdata` at its closing edge. In the next cycle, `rd_valid`=1 and `rd_data` holds that sample. `rd_valid` is 0 at all other times.
- R10: Within a sequential run, `bus_write` and `bus_word` never change from one memory cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 32 | Read data returned to the core |
| bus_addr | output | 32 | Address for the next bus cycle |
| bus_write | output | 1 | Direction for the next bus cycle, 1 = write |
| bus_word | output | 1 | Size for the next bus cycle, 1 = word |
| bus_mreq | output | 1 | Next cycle is a memory cycle |
| bus_seq | output | 1 | Next memory cycle is sequential |
| bus_dout | output | 32 | Write data on the bus |
| bus_doe | output | 1 | Write data drive enable for this cycle |
| bus_rdata | input | 32 | Read data from the bus |

## Verification
Suppose the registered copy of the previous address or controls is wrong. Then the next request that could chain is misclassified, and this shows one cycle after its accepting edge as a wrong `bus_mreq`/`bus_seq` pair. A stuck pending flag shows up in the same cycle: `req_ready` is wrong, and then the address is not held. Errors in the data stages appear one cycle into the memory cycle on `bus_doe`/`bus_dout`, or one cycle after it closes on `rd_valid`/`rd_data`. Random runs with frequent consecutive addresses, direction and size flips, and 256-word crossings reach all of these paths within a few requests.

// File: rtl/mem_bus_sequencer.sv
module mem_bus_sequencer #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int RUN_BITS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_word,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] bus_addr,
  output logic          bus_write,
  output logic          bus_word,
  output logic          bus_mreq,
  output logic          bus_seq,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic [DW-1:0] bus_rdata
);
  localparam int LO = 2;
  localparam int HI = LO + RUN_BITS - 1;

  logic          pend, mem_now, mem_wr;
  logic [DW-1:0] wdata_q;
  logic          chain;

  assign req_ready = ~pend;
  assign bus_doe   = mem_wr;
  assign chain = bus_mreq && req_write == bus_write && req_word == bus_word &&
                 req_addr == bus_addr + AW'(4) && |req_addr[HI:LO];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      bus_mreq  <= 1'b0;
      bus_seq   <= 1'b0;
      bus_addr  <= '0;
      bus_write <= 1'b0;
      bus_word  <= 1'b0;
      wdata_q   <= '0;
      mem_now   <= 1'b0;
      mem_wr    <= 1'b0;
      bus_dout  <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      if (pend) begin
        pend     <= 1'b0;
        bus_mreq <= 1'b1;
        bus_seq  <= 1'b0;
      end else if (req_valid) begin
        bus_addr  <= req_addr;
        bus_write <= req_write;
        bus_word  <= req_word;
        wdata_q   <= req_wdata;
        bus_mreq  <= chain;
        bus_seq   <= chain;
        pend      <= ~chain;
      end else begin
        bus_mreq <= 1'b0;
        bus_seq  <= 1'b0;
      end
      mem_now <= bus_mreq;
      mem_wr  <= bus_mreq & bus_write;
      if (bus_mreq) bus_dout <= wdata_q;
      rd_valid <= mem_now & ~mem_wr;
      if (mem_now && !mem_wr) rd_data <= bus_rdata;
    end
  end

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> bus_mreq && !bus_seq && $stable(bus_addr) && $stable(bus_write) && $stable(bus_word));
  assert_idle_no_mreq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !bus_mreq && !bus_seq);
  assert_seq_controls_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mreq && bus_seq |-> $past(bus_mreq) && bus_write == $past(bus_write) &&
                            bus_word == $past(bus_word) && bus_addr == $past(bus_addr) + AW'(4));
  assert_run_break_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mreq && bus_seq |-> bus_addr[HI:LO] != '0);
  assert_gap_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && !req_valid |=> !bus_mreq && !bus_seq);
  assert_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> $past(bus_mreq && bus_write));
  assert_read_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bus_mreq && !bus_write, 2));
endmodule

// File: tb/test_mem_bus_sequencer.sv
`timescale 1ns/1ps
module test_mem_bus_sequencer;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_word = 1;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic req_ready, rd_valid, bus_write, bus_word, bus_mreq, bus_seq, bus_doe;
  logic [31:0] rd_data, bus_addr, bus_dout, bus_rdata, tb_mem_addr = 0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  mem_bus_sequencer i_mem_bus_sequencer (.*);

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], ~a[31:16]} ^ 32'h5A5A_3C3C;
  endfunction

  always @(posedge clk) if (bus_mreq) tb_mem_addr <= bus_addr;
  assign bus_rdata = mem_word(tb_mem_addr);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model state
  bit m_mreq, m_seq, m_pend, m_w, m_b, m_mem, m_memw, m_rdv, p_w, p_b;
  logic [31:0] m_addr, m_wd, m_memaddr, m_dout, m_rd;
  string m_tag = "R1";

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(req_ready && !bus_mreq && !bus_seq && !bus_doe && !rd_valid, "R1 reset",
          {req_ready, bus_mreq, bus_seq, bus_doe, rd_valid}, 5'b10000);
      m_mreq = 0; m_seq = 0; m_pend = 0; m_w = 0; m_b = 0; m_addr = 0; m_wd = 0;
      m_mem = 0; m_memw = 0; m_rdv = 0; m_memaddr = 0; m_dout = 0; m_rd = 0; m_tag = "R1";
    end else begin
      chk(bus_mreq == m_mreq, m_tag, bus_mreq, m_mreq);
      chk(bus_seq == m_seq, m_tag, bus_seq, m_seq);
      chk(req_ready == !m_pend, "R2 ready", req_ready, !m_pend);
      if (m_mreq || m_pend)
        chk(bus_addr == m_addr && bus_write == m_w && bus_word == m_b, m_tag, bus_addr, m_addr);
      chk(bus_doe == m_memw, "R8 drive", bus_doe, m_memw);
      if (m_memw) chk(bus_dout == m_dout, "R8 data", bus_dout, m_dout);
      chk(rd_valid == m_rdv, "R9 valid", rd_valid, m_rdv);
      if (m_rdv) chk(rd_data == m_rd, "R9 data", rd_data, m_rd);
      if (bus_mreq && bus_seq)
        chk(bus_write == p_w && bus_word == p_b, "R10 stable", {bus_write, bus_word}, {p_w, p_b});
      p_w = bus_write; p_b = bus_word;
      // advance model to next cycle
      m_rdv = m_mem && !m_memw;
      m_rd = mem_word(m_memaddr);
      m_mem = m_mreq; m_memw = m_mreq && m_w;
      if (m_mreq) begin m_memaddr = m_addr; m_dout = m_wd; end
      if (m_pend) begin
        m_pend = 0; m_mreq = 1; m_seq = 0; m_tag = "R7 hold";
      end else if (req_valid) begin
        if (!m_mreq) m_tag = "R6 after gap";
        else if (req_write != m_w || req_word != m_b) m_tag = "R4 type change";
        else if (req_addr != m_addr + 4) m_tag = "R2 nonsequential";
        else if (req_addr[9:2] == 0) m_tag = "R5 boundary";
        else m_tag = "R3 sequential";
        m_seq = (m_tag == "R3 sequential");
        m_mreq = m_seq; m_pend = !m_seq;
        m_addr = req_addr; m_w = req_write; m_b = req_word; m_wd = req_wdata;
      end else begin
        m_mreq = 0; m_seq = 0; m_tag = "R6 idle";
      end
    end
  end

  task automatic send(input logic [31:0] a, input bit w, input bit b);
    bit ok;
    req_valid = 1; req_addr = a; req_write = w; req_word = b; req_wdata = $urandom;
    forever begin
      @(negedge clk); ok = req_ready;
      @(posedge clk);
      if (ok) break;
    end
    #1 req_valid = 0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    logic [31:0] a;
    bit w, b;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // directed: word read burst, then write at A+4 (R4), size change (R4)
    send(32'h100, 0, 1); send(32'h104, 0, 1); send(32'h108, 0, 1);
    send(32'h10C, 1, 1); send(32'h110, 1, 1); send(32'h114, 1, 0);
    // boundary crossing (R5) and resume
    send(32'h3F8, 0, 1); send(32'h3FC, 0, 1); send(32'h400, 0, 1); send(32'h404, 0, 1);
    // gap then consecutive (R6)
    gap(2); send(32'h408, 0, 1); send(32'h40C, 0, 1);
    a = 32'h2000; w = 0; b = 1;
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 65) a = a + 4;
      else if (r < 75) a = {$urandom_range(0, 255), 10'h3FC};
      else if (r < 85) a = {$urandom, 2'b00};
      else a = a + 4 * $urandom_range(2, 5);
      if ($urandom_range(0, 9) == 0) w = !w;
      if ($urandom_range(0, 11) == 0) b = !b;
      send(a, w, b);
      if ($urandom_range(0, 7) == 0) gap($urandom_range(1, 3));
    end
    gap(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule